// File: doc/BRIEF.md
# Programmable Frame-Sync Generator

This block turns a bit-clock enable into a frame-sync (word-select) waveform for serial audio links. The high and low phases of the waveform are programmed separately, each as a count of bit-clock ticks minus one. Any bit-clock-to-frame ratio can therefore be produced, from a plain two-channel I2S frame to a long TDM frame. When the ratio R is odd, software writes a high count of R/2-1 and a low count of (R+1)/2-1. The low phase is then one tick longer than the high phase, which gives a near-even duty cycle.

A small write-only register port holds the settings. These are a run bit, a 4-bit clock-source selector, the high and low phase counts, and a master-clock word with an enable bit and a 4-bit divider. The source selector and the master-clock word are only stored and shown on status outputs. Besides the frame-sync level, the block gives a one-cycle frame-start strobe for the serializers that follow it. New phase counts are taken in only at a frame boundary.

Top module: `frame_sync_gen`

## Requirements
- R1: After reset the block is stopped: `fsync` and `frame_start` are 0, `clk_src_sel` is 0, `mclk_en` is 0, `mclk_div` is 1 and both phase counts are 0.
- R2: While the run bit (address 0, bit 0) is 0, `fsync` and `frame_start` stay 0. Clearing the bit in the middle of a frame forces both to 0 from the first clock after the write edge.
- R3: Once running, the first bit-clock tick starts a high phase, and `frame_start` is 1 in that first high cycle.
- R4: The high phase lasts (H+1) ticks and the low phase lasts (L+1) ticks. H is the high count at address 2 and L is the low count at address 3, each in bits [PER_W-1:0].
- R5: `frame_start` is high for exactly one clock, in the first clock of each high phase, and at no other time.
- R6: Phase counts written while a frame is in progress do not change that frame. They apply from the next frame start.
- R7: `fsync` changes only on a clock edge at which `bclk_en` is 1, except when the run bit is cleared.
- R8: Address 1 bits [3:0] set `clk_src_sel` (0 = no source, n+1 = cluster n); the other bits of the word are ignored.
- R9: Address 4 holds the master-clock word: bit 0 drives `mclk_en` and bits [11:8] drive `mclk_div`.
- R10: Writes to addresses 5 to 7 change no setting and do not disturb a running frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bclk_en | input | 1 | One-clock enable marking each bit-clock tick |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | DATA_W | Register write data |
| fsync | output | 1 | Frame-sync level |
| frame_start | output | 1 | One-clock strobe at the start of each high phase |
| clk_src_sel | output | 4 | Stored clock-source selector |
| mclk_en | output | 1 | Stored master-clock enable |
| mclk_div | output | 4 | Stored master-clock divider |

## Verification
The assertions assume that `bclk_en` is a one-clock strobe, with gaps between strobes of any length. They also assume that register writes are single-cycle pulses whose data is valid with the strobe. The stimulus drives inputs at the falling edge, writes one register per pulse and generates `bclk_en` at a fixed division of the clock: every clock for most ratios and every third clock to check gapped ticks. Phase counts are changed either while the generator is stopped or inside a high phase that is long enough to hold both writes. The boundary-deferral rule is therefore tested in a known part of the frame.

// File: rtl/fsg_pkg.sv
// Package: shared types and the register address map of the frame-sync
// generator. Assumes a 3-bit word address on the register port.
package fsg_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_HIGH = 2'd1,
        PH_LOW  = 2'd2
    } fsg_phase_e;

    localparam int unsigned ADDR_W   = 3;
    localparam int unsigned SEL_W    = 4;
    localparam int unsigned MDIV_LSB = 8;
    localparam int unsigned MDIV_W   = 4;

    localparam logic [ADDR_W-1:0] A_RUN    = 3'd0;
    localparam logic [ADDR_W-1:0] A_SRCSEL = 3'd1;
    localparam logic [ADDR_W-1:0] A_HICNT  = 3'd2;
    localparam logic [ADDR_W-1:0] A_LOCNT  = 3'd3;
    localparam logic [ADDR_W-1:0] A_MCLK   = 3'd4;

endpackage

// File: rtl/fsg_regs.sv
// Module: fsg_regs
// Holds the settings written over the single-cycle register port: run bit,
// clock-source selector, high/low phase counts and the master-clock word.
// Assumes PER_W <= DATA_W and DATA_W >= MDIV_LSB + MDIV_W. Unmapped
// addresses are dropped.
module fsg_regs
    import fsg_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned PER_W  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              run_o,
    output logic [SEL_W-1:0]  src_o,
    output logic [PER_W-1:0]  hi_o,
    output logic [PER_W-1:0]  lo_o,
    output logic              mclk_en_o,
    output logic [MDIV_W-1:0] mclk_div_o
);

    localparam int unsigned MDIV_TOP = MDIV_LSB + MDIV_W;
    localparam int unsigned USED_W   = (PER_W > MDIV_TOP) ? PER_W : MDIV_TOP;

    // Register write decode and storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_o      <= 1'b0;
            src_o      <= '0;
            hi_o       <= '0;
            lo_o       <= '0;
            mclk_en_o  <= 1'b0;
            mclk_div_o <= MDIV_W'(1);
        end else if (wr_en) begin
            case (wr_addr)
                A_RUN:    run_o <= wr_data[0];
                A_SRCSEL: src_o <= wr_data[SEL_W-1:0];
                A_HICNT:  hi_o  <= wr_data[PER_W-1:0];
                A_LOCNT:  lo_o  <= wr_data[PER_W-1:0];
                A_MCLK: begin
                    mclk_en_o  <= wr_data[0];
                    mclk_div_o <= wr_data[MDIV_TOP-1:MDIV_LSB];
                end
                default: ;
            endcase
        end
    end

    // Upper data bits that no register takes.
    generate
        if (DATA_W > USED_W) begin : g_spare
            logic spare_unused;
            assign spare_unused = ^wr_data[DATA_W-1:USED_W];
        end
    endgenerate

    // R8: the selector takes only the low nibble of the written word.
    a_r8_src_nibble: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == A_SRCSEL) |=> (src_o == $past(wr_data[SEL_W-1:0])));

    // R9: the master-clock word splits into enable and divider.
    a_r9_mclk_fields: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == A_MCLK) |=>
            (mclk_en_o == $past(wr_data[0]) &&
             mclk_div_o == $past(wr_data[MDIV_TOP-1:MDIV_LSB])));

    // R10: unmapped addresses leave every setting alone.
    a_r10_unmapped: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr > A_MCLK) |=>
            ($stable(run_o) && $stable(src_o) && $stable(hi_o) &&
             $stable(lo_o) && $stable(mclk_en_o) && $stable(mclk_div_o)));

endmodule

// File: rtl/fsg_phase_core.sv
// Module: fsg_phase_core
// Counts bit-clock ticks through a high and a low phase. Both phase counts
// are latched at each frame start, so a frame keeps the lengths it began
// with. Assumes tick_i is a one-clock strobe. Clearing run_i idles it at once.
module fsg_phase_core
    import fsg_pkg::*;
#(
    parameter int unsigned PER_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             tick_i,
    input  logic [PER_W-1:0] hi_i,
    input  logic [PER_W-1:0] lo_i,
    output logic             fsync_o,
    output logic             frame_start_o
);

    fsg_phase_e       phase_q, phase_d;
    logic [PER_W-1:0] cnt_q, cnt_d;
    logic [PER_W-1:0] act_hi_q, act_hi_d;
    logic [PER_W-1:0] act_lo_q, act_lo_d;
    logic             pulse_q, pulse_d;
    logic             new_frame;

    // Next-state logic: advance one tick, and latch the counts at a frame start.
    always_comb begin
        phase_d   = phase_q;
        cnt_d     = cnt_q;
        new_frame = 1'b0;
        if (!run_i) begin
            phase_d = PH_IDLE;
            cnt_d   = '0;
        end else if (tick_i) begin
            case (phase_q)
                PH_IDLE: new_frame = 1'b1;
                PH_HIGH: begin
                    if (cnt_q == act_hi_q) begin
                        phase_d = PH_LOW;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
                PH_LOW: begin
                    if (cnt_q == act_lo_q) new_frame = 1'b1;
                    else                   cnt_d     = cnt_q + 1'b1;
                end
                default: phase_d = PH_IDLE;
            endcase
            if (new_frame) begin
                phase_d = PH_HIGH;
                cnt_d   = '0;
            end
        end
        act_hi_d = new_frame ? hi_i : act_hi_q;
        act_lo_d = new_frame ? lo_i : act_lo_q;
        pulse_d  = new_frame;
    end

    // State registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q  <= PH_IDLE;
            cnt_q    <= '0;
            act_hi_q <= '0;
            act_lo_q <= '0;
            pulse_q  <= 1'b0;
        end else begin
            phase_q  <= phase_d;
            cnt_q    <= cnt_d;
            act_hi_q <= act_hi_d;
            act_lo_q <= act_lo_d;
            pulse_q  <= pulse_d;
        end
    end

    // Outputs are gated by the run bit so that a stop takes effect at once.
    assign fsync_o       = run_i && (phase_q == PH_HIGH);
    assign frame_start_o = run_i && pulse_q;

    // R2: a stopped generator is idle one edge later.
    a_r2_idle_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> (phase_q == PH_IDLE));

    // R3: a frame-start strobe always falls in a high phase.
    a_r3_start_in_high: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_q |-> (phase_q == PH_HIGH && cnt_q == '0));

    // R4: the counter never runs past the latched phase count.
    a_r4_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_HIGH) |-> (cnt_q <= act_hi_q));

    // R5: the strobe is a single clock wide.
    a_r5_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start_o |=> !frame_start_o);

    // R6: latched counts move only together with a frame-start strobe.
    a_r6_counts_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        !pulse_q |-> ($stable(act_hi_q) && $stable(act_lo_q)));

    // R7: without a tick the phase holds while running.
    a_r7_moves_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && !tick_i) |=> (!run_i || $stable(phase_q)));

endmodule

// File: rtl/frame_sync_gen.sv
// Module: frame_sync_gen (top)
// Frame-sync generator: a register block feeds a tick-driven phase core.
// Assumes bclk_en is synchronous to clk and that the register port writes
// one word per strobe. The clock selector and master-clock word are only
// stored and shown on status outputs.
module frame_sync_gen
    import fsg_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned PER_W  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bclk_en,
    input  logic              wr_en,
    input  logic [2:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              fsync,
    output logic              frame_start,
    output logic [3:0]        clk_src_sel,
    output logic              mclk_en,
    output logic [3:0]        mclk_div
);

    logic             run;
    logic [PER_W-1:0] hi_cnt;
    logic [PER_W-1:0] lo_cnt;

    fsg_regs #(
        .DATA_W (DATA_W),
        .PER_W  (PER_W)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .run_o      (run),
        .src_o      (clk_src_sel),
        .hi_o       (hi_cnt),
        .lo_o       (lo_cnt),
        .mclk_en_o  (mclk_en),
        .mclk_div_o (mclk_div)
    );

    fsg_phase_core #(
        .PER_W (PER_W)
    ) u_core (
        .clk           (clk),
        .rst_n         (rst_n),
        .run_i         (run),
        .tick_i        (bclk_en),
        .hi_i          (hi_cnt),
        .lo_i          (lo_cnt),
        .fsync_o       (fsync),
        .frame_start_o (frame_start)
    );

    // R1: reset leaves the outputs idle and the divider at its normal value.
    a_r1_reset_state: assert property (@(posedge clk)
        !rst_n |=> (!fsync && !frame_start && clk_src_sel == 4'd0 &&
                    !mclk_en && mclk_div == 4'd1));

endmodule

// File: tb/frame_sync_gen_test.sv
module frame_sync_gen_test;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bclk_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        fsync, frame_start;
    logic [3:0]  clk_src_sel, mclk_div;
    logic        mclk_en;

    int n_cmp = 0;
    int n_bad = 0;
    int tick_div = 1;
    int tick_ctr = 0;
    bit done = 0;

    frame_sync_gen uut (
        .clk(clk), .rst_n(rst_n), .bclk_en(bclk_en),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .fsync(fsync), .frame_start(frame_start),
        .clk_src_sel(clk_src_sel), .mclk_en(mclk_en), .mclk_div(mclk_div)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Bit-clock tick: one clock in every tick_div.
    initial begin
        forever begin
            @(negedge clk);
            tick_ctr = (tick_ctr + 1 >= tick_div) ? 0 : tick_ctr + 1;
            bclk_en  = (tick_ctr == 0);
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic reg_wr(input logic [2:0] a, input logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_rise();
        do @(negedge clk); while (fsync !== 1'b1);
    endtask

    // Starts at the first high sample of a frame, ends at the next one.
    task automatic frame_lengths(output int h, output int l, output int bad);
        h = 0; l = 0; bad = 0;
        while (fsync === 1'b1) begin
            h++;
            if (frame_start !== (h == 1)) bad++;
            @(negedge clk);
        end
        while (fsync === 1'b0) begin
            l++;
            if (frame_start !== 1'b0) bad++;
            @(negedge clk);
        end
    endtask

    task automatic run_ratio(input int r, input int div);
        int h, l, bad;
        tick_div = div;
        reg_wr(3'd2, 32'(r/2 - 1));
        reg_wr(3'd3, 32'((r+1)/2 - 1));
        reg_wr(3'd0, 32'd1);
        wait_rise();
        chk($sformatf("R3 first high has strobe r=%0d", r), int'(frame_start), 1);
        for (int f = 0; f < 2; f++) begin
            frame_lengths(h, l, bad);
            chk($sformatf("R4 high r=%0d div=%0d", r, div), h, (r/2)*div);
            chk($sformatf("R4 low r=%0d div=%0d", r, div), l, ((r+1)/2)*div);
            chk($sformatf("R5 strobe r=%0d", r), bad, 0);
        end
        if (div > 1) chk("R7 high length is whole ticks", h % div, 0);
        reg_wr(3'd0, 32'd0);
        chk("R2 stopped", int'(fsync), 0);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        int h, l, bad, stuck;
        repeat (3) @(negedge clk);
        // R1 reset values.
        chk("R1 fsync", int'(fsync), 0);
        chk("R1 frame_start", int'(frame_start), 0);
        chk("R1 clk_src_sel", int'(clk_src_sel), 0);
        chk("R1 mclk_en", int'(mclk_en), 0);
        chk("R1 mclk_div", int'(mclk_div), 1);
        rst_n = 1'b1;
        @(negedge clk);

        // R2: not running, ticks present, output stays idle.
        stuck = 0;
        repeat (20) begin @(negedge clk); if (fsync || frame_start) stuck++; end
        chk("R2 idle while stopped", stuck, 0);

        // R1: reset phase counts give a 1/1 frame.
        reg_wr(3'd0, 32'd1);
        wait_rise();
        frame_lengths(h, l, bad);
        chk("R1 default high", h, 1);
        chk("R1 default low", l, 1);
        reg_wr(3'd0, 32'd0);

        // R4/R5 sweep of ratios, continuous and gapped ticks.
        run_ratio(2, 1);
        run_ratio(3, 1);
        run_ratio(32, 1);
        run_ratio(33, 1);
        run_ratio(64, 1);
        run_ratio(256, 1);
        run_ratio(33, 3);
        run_ratio(7, 3);
        tick_div = 1;

        // R2: stop mid-frame, then R3 restart from a full high phase.
        reg_wr(3'd2, 32'd31);
        reg_wr(3'd3, 32'd31);
        reg_wr(3'd0, 32'd1);
        wait_rise();
        repeat (5) @(negedge clk);
        reg_wr(3'd0, 32'd0);
        chk("R2 fsync drops at once", int'(fsync), 0);
        chk("R2 no strobe after stop", int'(frame_start), 0);
        stuck = 0;
        repeat (20) begin @(negedge clk); if (fsync || frame_start) stuck++; end
        chk("R2 stays idle", stuck, 0);
        reg_wr(3'd0, 32'd1);
        wait_rise();
        frame_lengths(h, l, bad);
        chk("R3 restart full high", h, 32);
        chk("R3 restart low", l, 32);
        reg_wr(3'd0, 32'd0);

        // R6: counts written mid-frame apply next frame.
        reg_wr(3'd2, 32'd15);
        reg_wr(3'd3, 32'd15);
        reg_wr(3'd0, 32'd1);
        wait_rise();
        fork
            frame_lengths(h, l, bad);
            begin
                repeat (3) @(negedge clk);
                reg_wr(3'd2, 32'd3);
                reg_wr(3'd3, 32'd5);
            end
        join
        chk("R6 current frame high kept", h, 16);
        chk("R6 current frame low kept", l, 16);
        frame_lengths(h, l, bad);
        chk("R6 next frame high", h, 4);
        chk("R6 next frame low", l, 6);
        chk("R6 strobe", bad, 0);

        // R10: unmapped writes while running.
        reg_wr(3'd5, 32'hFFFF_FFFF);
        reg_wr(3'd6, 32'hFFFF_FFFF);
        reg_wr(3'd7, 32'h0000_0000);
        wait_rise();
        frame_lengths(h, l, bad);
        chk("R10 frame high unchanged", h, 4);
        chk("R10 frame low unchanged", l, 6);
        chk("R10 clk_src_sel unchanged", int'(clk_src_sel), 0);
        chk("R10 mclk_en unchanged", int'(mclk_en), 0);
        chk("R10 mclk_div unchanged", int'(mclk_div), 1);
        reg_wr(3'd0, 32'd0);

        // R8 selector nibble.
        reg_wr(3'd1, 32'h0000_ABC5);
        chk("R8 selector low nibble", int'(clk_src_sel), 5);
        reg_wr(3'd1, 32'hFFFF_FFF0);
        chk("R8 selector zero", int'(clk_src_sel), 0);

        // R9 master-clock word.
        reg_wr(3'd4, 32'hFFFF_FA01);
        chk("R9 mclk_en set", int'(mclk_en), 1);
        chk("R9 mclk_div field", int'(mclk_div), 10);
        reg_wr(3'd4, 32'h0000_00FE);
        chk("R9 mclk_en clear", int'(mclk_en), 0);
        chk("R9 mclk_div clear", int'(mclk_div), 0);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule